// File: doc/BRIEF.md
# Event Notification Controller with State Scratchpad

This block is the host side of a bridge that sends an event notification command to an attached storage device. The command goes through the device's task-file registers. The block watches a handful of level inputs: the bus suspend state, media presence, the eject button and the negotiated link speed. It turns every edge of interest into a sticky flag.

When software pulses `start`, the controller runs the full exchange with no further help:

- It writes the pending flags, then two saved state bytes, then the command code.
- It polls the status register until the device reports completion.
- It reads back two fresh state bytes.

Those two bytes go out with the next command. This lets a device that loses power during a suspend keep a small amount of context on the host side.

An `abort` input models a bus reset arriving partway through. It returns the controller to idle and leaves both the stored state bytes and the undelivered flags untouched. Flags are cleared only by a command that completes, and only the flags that command actually carried.

Top module: `evt_notify_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy`, `done`, `reg_wr` and `reg_rd` are 0, all event flags are 0 and both stored state bytes are 0x00.
- R2: A `start` pulse seen while idle produces writes on four consecutive cycles, beginning the cycle after `start`:
  - address 2 carries the event byte;
  - address 4 carries state byte 0;
  - address 5 carries state byte 1;
  - address 7 carries `CMD_CODE`.
  
  Status reads at address 7 follow on the next cycle.
- R3: Event byte bit positions are fixed:
  - bit 0 is set by a falling edge of `bus_suspend`;
  - bit 1 is set by a rising edge of `media_present`;
  - bit 2 is set by a falling edge of `media_present`;
  - bit 3 is set by a rising edge of `eject_btn`;
  - bit 4 is set by a falling edge of `eject_btn`;
  - bit 7 is always 0.
- R4: `link_speed` code 01 means full speed and sets bit 5; code 10 means high speed and sets bit 6. A change into either code sets that code's bit and clears the other speed bit, so bits 5 and 6 are never both 1.
- R5: Polling continues while status bit 7 (busy) or status bit 3 (data request) is 1. On the first status read with both bits 0, the block reads address 4 and then address 5 on the next two cycles. `done` pulses for exactly one cycle right after the address 5 read.
- R6: The bytes read from addresses 4 and 5 in a completed command are the state bytes written at addresses 4 and 5 by the next command.
- R7: A completed command clears only the flags it wrote. Any event that arrives after the event byte was written stays pending for the next command.
- R8: `abort` during a command returns the block to idle at the next edge with no `done`. The stored state bytes and all pending flags are kept.
- R9: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a notification command |
| abort | input | 1 | Bus reset; cancels a command in progress |
| bus_suspend | input | 1 | Level, 1 while the bus is suspended |
| media_present | input | 1 | Level, 1 while media is inserted |
| eject_btn | input | 1 | Level, 1 while the eject button is held |
| link_speed | input | 2 | 01 full speed, 10 high speed, others none |
| reg_wr | output | 1 | Task-file write strobe |
| reg_rd | output | 1 | Task-file read strobe |
| reg_addr | output | 3 | Task-file register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_rd` is high |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on successful completion |

## Verification
The bench exercises the following cases:

- **Status with data request set.** It returns a status that has busy clear but data request set. A controller that looked only at the busy bit would move on to the readback one poll too early, and the poll count would be wrong.
- **Event during a command.** It injects a media insertion while a command is running. A design that cleared every flag on completion would drop that event from the following event byte.
- **Abort mid-poll.** It aborts during polling. A design that committed or cleared on abort would send changed state bytes or an empty event byte on the retry.
- **Speed flip-flop.** It switches the link speed back and forth before a command. A design that kept the older speed bit would report both speeds at once.
- **Start while busy.** It pulses `start` while busy. Any restart would show up as an unexpected write on the scoreboard.

// File: rtl/evt_notify_ctrl.sv
module evt_notify_ctrl #(
  parameter int          DW       = 8,
  parameter int          AW       = 3,
  parameter logic [7:0]  CMD_CODE = 8'hDA,
  parameter logic [2:0]  A_EVT    = 3'd2,
  parameter logic [2:0]  A_ST0    = 3'd4,
  parameter logic [2:0]  A_ST1    = 3'd5,
  parameter logic [2:0]  A_CMD    = 3'd7,
  parameter int          BSY_BIT  = 7,
  parameter int          DRQ_BIT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          bus_suspend,
  input  logic          media_present,
  input  logic          eject_btn,
  input  logic [1:0]    link_speed,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {
    S_IDLE, S_WEVT, S_WS0, S_WS1, S_WCMD, S_POLL, S_RS0, S_RS1
  } state_t;

  state_t        st, st_n;
  logic [DW-1:0] st0, st1, nst0, flags, flags_n, sent;
  logic          susp_q, med_q, btn_q;
  logic [1:0]    spd_q;
  logic          fs_chg, hs_chg, commit, finished;
  logic [6:0]    ev_set;

  assign fs_chg = (link_speed == 2'b01) && (spd_q != 2'b01);
  assign hs_chg = (link_speed == 2'b10) && (spd_q != 2'b10);
  assign ev_set = {hs_chg, fs_chg,
                   btn_q & ~eject_btn, ~btn_q & eject_btn,
                   med_q & ~media_present, ~med_q & media_present,
                   susp_q & ~bus_suspend};

  assign commit   = (st == S_RS1) && !abort;
  assign finished = !reg_rdata[BSY_BIT] && !reg_rdata[DRQ_BIT];

  always_comb begin
    flags_n = (flags & ~(commit ? sent : '0)) | {{(DW-7){1'b0}}, ev_set};
    if (fs_chg) flags_n[6] = 1'b0;
    if (hs_chg) flags_n[5] = 1'b0;
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (start) st_n = S_WEVT;
      S_WEVT: st_n = S_WS0;
      S_WS0:  st_n = S_WS1;
      S_WS1:  st_n = S_WCMD;
      S_WCMD: st_n = S_POLL;
      S_POLL: if (finished) st_n = S_RS0;
      S_RS0:  st_n = S_RS1;
      S_RS1:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (abort && st != S_IDLE) st_n = S_IDLE;
  end

  assign busy   = (st != S_IDLE);
  assign reg_wr = (st == S_WEVT) || (st == S_WS0) || (st == S_WS1) || (st == S_WCMD);
  assign reg_rd = (st == S_POLL) || (st == S_RS0) || (st == S_RS1);

  always_comb begin
    reg_addr  = A_CMD;
    reg_wdata = '0;
    case (st)
      S_WEVT: begin reg_addr = A_EVT; reg_wdata = flags; end
      S_WS0:  begin reg_addr = A_ST0; reg_wdata = st0;   end
      S_WS1:  begin reg_addr = A_ST1; reg_wdata = st1;   end
      S_WCMD: begin reg_addr = A_CMD; reg_wdata = CMD_CODE; end
      S_RS0:  reg_addr = A_ST0;
      S_RS1:  reg_addr = A_ST1;
      default: reg_addr = A_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      st0 <= '0; st1 <= '0; nst0 <= '0;
      flags <= '0; sent <= '0; done <= 1'b0;
      susp_q <= 1'b0; med_q <= 1'b0; btn_q <= 1'b0; spd_q <= 2'b00;
    end else begin
      st     <= st_n;
      susp_q <= bus_suspend;
      med_q  <= media_present;
      btn_q  <= eject_btn;
      spd_q  <= link_speed;
      flags  <= flags_n;
      done   <= commit;
      if (st == S_WEVT) sent <= flags;
      else              sent <= sent & ~{{(DW-7){1'b0}}, ev_set};
      if (st == S_RS0) nst0 <= reg_rdata;
      if (commit) begin
        st0 <= nst0;
        st1 <= reg_rdata;
      end
    end
  end

  p_speed_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[6:5]));

  p_done_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(reg_rd && reg_addr == A_ST1));

  p_poll_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CMD && !abort) |=> (reg_rd && reg_addr == A_CMD));

  p_abort_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && !done && $stable(st0) && $stable(st1)));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_rd && reg_addr == A_CMD && !abort && reg_rdata[BSY_BIT]) |=> !reg_wr);

endmodule

// File: tb/test_evt_notify_ctrl.sv
module test_evt_notify_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CMD = 8'hDA;

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic bus_suspend = 0, media_present = 0, eject_btn = 0;
  logic [1:0] link_speed = 2'b00;
  logic reg_wr, reg_rd, busy, done;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0, cycles = 0;
  int bsy_left = 0, drq_left = 0, polls = 0;
  logic [7:0] dev_s0 = 0, dev_s1 = 0;
  logic prev_rd5 = 0, done_seen = 0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_notify_ctrl #(.CMD_CODE(CMD)) i_evt_notify_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .bus_suspend(bus_suspend), .media_present(media_present),
    .eject_btn(eject_btn), .link_speed(link_speed),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done));

  always_comb begin
    case (reg_addr)
      3'd4: reg_rdata = dev_s0;
      3'd5: reg_rdata = dev_s1;
      3'd7: reg_rdata = (bsy_left > 0) ? 8'h80 : (drq_left > 0) ? 8'h58 : 8'h50;
      default: reg_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (reg_rd && reg_addr == 3'd7) begin
      if (bsy_left > 0) bsy_left <= bsy_left - 1;
      else if (drq_left > 0) drq_left <= drq_left - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cycles++;
    if (reg_wr) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R2/R3/R6 write", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_rd && reg_addr == 3'd7) polls++;
    if (done) begin
      done_seen = 1;
      check(prev_rd5, "R5 done after read of address 5", prev_rd5, 1);
    end
    prev_rd5 = reg_rd && reg_addr == 3'd5;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic push_cmd(input logic [7:0] ev, input logic [7:0] s0, input logic [7:0] s1);
    exp_q.push_back({3'd2, ev});
    exp_q.push_back({3'd4, s0});
    exp_q.push_back({3'd5, s1});
    exp_q.push_back({3'd7, CMD});
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_cmd(input logic [7:0] ev, input logic [7:0] s0, input logic [7:0] s1,
                         input int nb, input int nd, input logic [7:0] n0, input logic [7:0] n1,
                         input bit extra);
    push_cmd(ev, s0, s1);
    bsy_left = nb; drq_left = nd; dev_s0 = n0; dev_s1 = n1;
    polls = 0; done_seen = 0;
    pulse_start();
    if (extra) begin
      repeat (6) @(negedge clk);
      start = 1; media_present = 1;   // R9 start while busy, R7 event during command
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk);
    check(done_seen, "R5 done pulse", done_seen, 1);
    check(polls == nb + nd + 1, "R5 poll count", polls, nb + nd + 1);
    @(negedge clk);
    check(!done && !busy, "R5 done one cycle, idle", {done, busy}, 0);
    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, reg_wr, reg_rd} == 4'b0, "R1 reset outputs", {busy, done, reg_wr, reg_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    check({busy, reg_wr, reg_rd} == 3'b0, "R1 idle after reset", {busy, reg_wr, reg_rd}, 0);

    // R1 R2: zero state and no events
    run_cmd(8'h00, 8'h00, 8'h00, 3, 1, 8'hA5, 8'h3C, 0);

    // R3 R4: insert, press, high speed
    @(negedge clk); media_present = 1; eject_btn = 1; link_speed = 2'b10;
    repeat (2) @(negedge clk);
    run_cmd(8'h4A, 8'hA5, 8'h3C, 2, 0, 8'h77, 8'h88, 0);   // R6 handoff

    // R3 R4: eject, release, resume, full speed; R7 R9 during command
    media_present = 0; eject_btn = 0; bus_suspend = 1; link_speed = 2'b01;
    @(negedge clk); bus_suspend = 0;
    repeat (2) @(negedge clk);
    run_cmd(8'h35, 8'h77, 8'h88, 6, 0, 8'h11, 8'h22, 1);
    repeat (3) @(negedge clk);
    check(!busy, "R9 no restart", busy, 0);

    // R8 abort while polling
    push_cmd(8'h02, 8'h11, 8'h22);
    bsy_left = 1000; polls = 0; done_seen = 0; dev_s0 = 8'hEE; dev_s1 = 8'hFF;
    pulse_start();
    while (polls < 2) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    check(!busy, "R8 idle after abort", busy, 0);
    repeat (3) @(negedge clk);
    check(!done_seen, "R8 no done on abort", done_seen, 0);
    check(exp_q.size() == 0, "R8 writes before abort", exp_q.size(), 0);
    bsy_left = 0;

    // R4 speed flip-flop; R8 retry keeps flags and state
    link_speed = 2'b10; @(negedge clk);
    link_speed = 2'b01; repeat (2) @(negedge clk);
    run_cmd(8'h22, 8'h11, 8'h22, 0, 0, 8'h5A, 8'hC3, 0);

    // R7 flags cleared after delivery; R6 again
    run_cmd(8'h00, 8'h5A, 8'hC3, 1, 0, 8'h00, 8'h00, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule